// File: doc/BRIEF.md
# Double-Buffered Converter Word Loader

This block is the digital front end of a 10-bit converter. It holds a staging word and a held output code. The staging word can be filled in two ways. In parallel use, two byte strobes are pulsed one at a time. The low-byte strobe captures data bits 7..0 and the high-byte strobe captures data bits 9..8. In serial use, both strobes are pulsed together. Each joint rise then shifts one bit from the serial input into the staging word, most significant bit first. The bit at the head of the chain is presented on a serial output, so several loaders can be chained. A mode input selects a 10-bit or an 8-bit serial word.

A level-sensitive load input makes the held output code follow the staging word. The held code is the value driven to the analog core. When a staging update and a load fall in the same cycle, the held code takes the updated word at that edge. The strobe inputs are synchronous to the clock.

Rising edges are found by a four-state tracker that records which strobes were high in the previous cycle:
- `ST_IDLE`: neither strobe high.
- `ST_LOW_HELD`: only the low strobe high.
- `ST_HIGH_HELD`: only the high strobe high.
- `ST_BOTH_HELD`: both strobes high.

Every cycle the tracker moves to the state that matches the current strobe levels, so any state can go to any state. From the state and the current levels it names one operation for the cycle:
- `OP_NONE`: no rise.
- `OP_LOW`: only the low strobe rose.
- `OP_HIGH`: only the high strobe rose.
- `OP_SHIFT`: both strobes rose in the same cycle.

Top module: `dac_load_front`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears both the staging word and the held code to zero.
- R2: A rise of only `stb_lo` loads `din[7:0]` into staging bits 7..0 and leaves staging bits 9..8 unchanged.
- R3: A rise of only `stb_hi` loads `din[9:8]` into staging bits 9..8 and leaves staging bits 7..0 unchanged.
- R4: At every clock edge where `load` is high, `code` takes the value the staging word holds after that edge.
- R5: When `load` is high at the same edge as a `stb_hi` rise, `code` shows the new word right after that edge.
- R6: While `load` is low, `code` does not change, whatever happens to the staging word.
- R7: When `stb_lo` and `stb_hi` rise in the same cycle, the staging word shifts by one position, `sdi` enters at the bottom of the active chain, and `din` has no effect.
- R8: With `long_word` = 1, ten joint rises carrying a word most significant bit first leave exactly that 10-bit word in staging.
- R9: With `long_word` = 0, eight joint rises carrying a byte most significant bit first leave it in staging bits 9..2, and bits 1..0 become 0.
- R10: `sdo` always equals staging bit 9, which is the bit that leaves the chain at the next shift, in both modes.
- R11: A strobe held high for several cycles acts only once, on its rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stb_lo | input | 1 | Low-byte strobe; also the serial clock when pulsed together with `stb_hi` |
| stb_hi | input | 1 | High-byte strobe; also the serial clock when pulsed together with `stb_lo` |
| din | input | 10 | Parallel data |
| long_word | input | 1 | Serial word length: 1 = 10 bits, 0 = 8 bits |
| sdi | input | 1 | Serial data in |
| load | input | 1 | Level-sensitive transfer from staging to the held code |
| sdo | output | 1 | Serial data out (staging bit 9) |
| code | output | 10 | Held code driven to the analog core |

## Verification
The load transfer and the high-byte capture can fall on the same clock edge. The bench provokes this on every fourth parallel word by raising `stb_hi` and `load` in the same cycle and then dropping `load` immediately. The test passes only if `code` already shows the new 10-bit word, not the previous staging value. The bench also checks the opposite case, where staging changes while `load` is low and `code` must not move.

// File: rtl/dlf_pkg.sv
package dlf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'b00,
        ST_LOW_HELD  = 2'b01,
        ST_HIGH_HELD = 2'b10,
        ST_BOTH_HELD = 2'b11
    } strobe_state_e;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_LOW   = 2'b01,
        OP_HIGH  = 2'b10,
        OP_SHIFT = 2'b11
    } stage_op_e;

endpackage

// File: rtl/dlf_strobe_tracker.sv
module dlf_strobe_tracker
    import dlf_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      stb_lo,
    input  logic      stb_hi,
    output stage_op_e op
);

    strobe_state_e state_q, state_d;
    logic lo_was, hi_was;
    logic lo_rise, hi_rise;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        unique case ({stb_hi, stb_lo})
            2'b00: state_d = ST_IDLE;
            2'b01: state_d = ST_LOW_HELD;
            2'b10: state_d = ST_HIGH_HELD;
            default: state_d = ST_BOTH_HELD;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE:      begin lo_was = 1'b0; hi_was = 1'b0; end
            ST_LOW_HELD:  begin lo_was = 1'b1; hi_was = 1'b0; end
            ST_HIGH_HELD: begin lo_was = 1'b0; hi_was = 1'b1; end
            default:      begin lo_was = 1'b1; hi_was = 1'b1; end
        endcase
        lo_rise = stb_lo && !lo_was;
        hi_rise = stb_hi && !hi_was;
        unique case ({hi_rise, lo_rise})
            2'b11:   op = OP_SHIFT;
            2'b01:   op = OP_LOW;
            2'b10:   op = OP_HIGH;
            default: op = OP_NONE;
        endcase
    end

    // R11: a strobe that stays high yields no second operation
    a_r11_no_repeat: assert property (@(posedge clk) disable iff (rst)
        (stb_lo && stb_hi) |=> (stb_lo && stb_hi) |-> (op == OP_NONE));

endmodule

// File: rtl/dlf_stage_reg.sv
module dlf_stage_reg
    import dlf_pkg::*;
#(
    parameter int WIDTH     = 10,
    parameter int HIGH_BITS = 2,
    parameter int SHORT_LEN = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  stage_op_e        op,
    input  logic [WIDTH-1:0] din,
    input  logic             long_word,
    input  logic             sdi,
    output logic [WIDTH-1:0] stage_q,
    output logic [WIDTH-1:0] stage_d
);

    localparam int LOW_BITS = WIDTH - HIGH_BITS;
    localparam int PAD      = WIDTH - SHORT_LEN;

    always_comb begin
        stage_d = stage_q;
        unique case (op)
            OP_LOW:  stage_d[LOW_BITS-1:0] = din[LOW_BITS-1:0];
            OP_HIGH: stage_d[WIDTH-1:LOW_BITS] = din[WIDTH-1:LOW_BITS];
            OP_SHIFT: begin
                if (long_word) begin
                    stage_d = {stage_q[WIDTH-2:0], sdi};
                end else begin
                    stage_d[WIDTH-1:PAD] = {stage_q[WIDTH-2:PAD], sdi};
                    stage_d[PAD-1:0]     = '0;
                end
            end
            default: stage_d = stage_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) stage_q <= '0;
        else     stage_q <= stage_d;
    end

    a_r1_stage_clear: assert property (@(posedge clk)
        rst |=> (stage_q == '0));

    a_r2_low_load: assert property (@(posedge clk) disable iff (rst)
        (op == OP_LOW) |=> (stage_q[LOW_BITS-1:0] == $past(din[LOW_BITS-1:0]))
                        && (stage_q[WIDTH-1:LOW_BITS] == $past(stage_q[WIDTH-1:LOW_BITS])));

    a_r3_high_load: assert property (@(posedge clk) disable iff (rst)
        (op == OP_HIGH) |=> (stage_q[WIDTH-1:LOW_BITS] == $past(din[WIDTH-1:LOW_BITS]))
                         && (stage_q[LOW_BITS-1:0] == $past(stage_q[LOW_BITS-1:0])));

    a_r7_shift_long: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SHIFT && long_word) |=> (stage_q[0] == $past(sdi))
                                       && (stage_q[WIDTH-1:1] == $past(stage_q[WIDTH-2:0])));

    a_r9_short_pad: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SHIFT && !long_word) |=> (stage_q[PAD-1:0] == '0)
                                        && (stage_q[PAD] == $past(sdi)));

endmodule

// File: rtl/dlf_hold_reg.sv
module dlf_hold_reg #(
    parameter int WIDTH = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] stage_d,
    output logic [WIDTH-1:0] code
);

    always_ff @(posedge clk) begin
        if (rst)       code <= '0;
        else if (load) code <= stage_d;
    end

    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(code));

    a_r4_follow: assert property (@(posedge clk) disable iff (rst)
        load |=> (code == $past(stage_d)));

    a_r1_code_clear: assert property (@(posedge clk)
        rst |=> (code == '0));

endmodule

// File: rtl/dac_load_front.sv
module dac_load_front
    import dlf_pkg::*;
#(
    parameter int WIDTH     = 10,
    parameter int HIGH_BITS = 2,
    parameter int SHORT_LEN = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stb_lo,
    input  logic             stb_hi,
    input  logic [WIDTH-1:0] din,
    input  logic             long_word,
    input  logic             sdi,
    input  logic             load,
    output logic             sdo,
    output logic [WIDTH-1:0] code
);

    stage_op_e        op;
    logic [WIDTH-1:0] stage_q;
    logic [WIDTH-1:0] stage_d;

    dlf_strobe_tracker u_track (
        .clk    (clk),
        .rst    (rst),
        .stb_lo (stb_lo),
        .stb_hi (stb_hi),
        .op     (op)
    );

    dlf_stage_reg #(
        .WIDTH     (WIDTH),
        .HIGH_BITS (HIGH_BITS),
        .SHORT_LEN (SHORT_LEN)
    ) u_stage (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .din       (din),
        .long_word (long_word),
        .sdi       (sdi),
        .stage_q   (stage_q),
        .stage_d   (stage_d)
    );

    dlf_hold_reg #(
        .WIDTH (WIDTH)
    ) u_hold (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .stage_d (stage_d),
        .code    (code)
    );

    assign sdo = stage_q[WIDTH-1];

    // R10: the head bit of the chain leaves at the next shift
    a_r10_chain_out: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SHIFT) |=> ($past(sdo) != sdo) || ($past(stage_q[WIDTH-2]) == sdo));

    // R5: a load together with a high-byte capture shows the new high bits
    a_r5_same_edge: assert property (@(posedge clk) disable iff (rst)
        (load && op == OP_HIGH) |=> (code[WIDTH-1:WIDTH-HIGH_BITS] == $past(din[WIDTH-1:WIDTH-HIGH_BITS])));

endmodule

// File: tb/test_dac_load_front.sv
module test_dac_load_front;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       stb_lo = 1'b0;
    logic       stb_hi = 1'b0;
    logic [9:0] din = '0;
    logic       long_word = 1'b1;
    logic       sdi = 1'b0;
    logic       load = 1'b0;
    logic       sdo;
    logic [9:0] code;

    int vectors = 0;
    int misses  = 0;
    bit summary_done = 1'b0;

    always #5 clk = ~clk;

    dac_load_front i_dac_load_front (
        .clk       (clk),
        .rst       (rst),
        .stb_lo    (stb_lo),
        .stb_hi    (stb_hi),
        .din       (din),
        .long_word (long_word),
        .sdi       (sdi),
        .load      (load),
        .sdo       (sdo),
        .code      (code)
    );

    task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!summary_done) begin
            summary_done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        end
    endtask

    // one strobe pulse: high for one cycle, then low; returns on the negedge after
    task automatic pulse(input logic lo, input logic hi, input logic [9:0] d,
                         input logic s, input logic ld);
        @(negedge clk);
        stb_lo = lo; stb_hi = hi; din = d; sdi = s; load = ld;
        @(negedge clk);
        stb_lo = 1'b0; stb_hi = 1'b0; load = 1'b0;
    endtask

    task automatic do_load();
        @(negedge clk);
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        misses++;
        vectors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [9:0] stage;
        logic [9:0] held;
        logic [9:0] w;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 code after reset", code, 10'h000);
        check("R10 sdo after reset", {9'b0, sdo}, 10'h000);

        // fill staging, then reset again: both registers must clear
        pulse(1'b1, 1'b0, 10'h0FF, 1'b0, 1'b0);
        pulse(1'b0, 1'b1, 10'h300, 1'b0, 1'b1);
        check("R1 precondition", code, 10'h3FF);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        check("R1 code cleared", code, 10'h000);
        do_load();
        check("R1 staging cleared", code, 10'h000);
        stage = '0; held = '0;

        // parallel sweep over every word
        for (int k = 0; k < 1024; k++) begin
            w = k[9:0];
            pulse(1'b1, 1'b0, {~w[9:8], w[7:0]}, 1'b0, 1'b0);
            stage[7:0] = w[7:0];
            check("R6 hold after low byte", code, held);
            if (k % 4 == 0) begin
                pulse(1'b0, 1'b1, {w[9:8], ~w[7:0]}, 1'b0, 1'b1);
                stage[9:8] = w[9:8];
                held = stage;
                check("R5 load with high strobe", code, w);
            end else begin
                pulse(1'b0, 1'b1, {w[9:8], ~w[7:0]}, 1'b0, 1'b0);
                stage[9:8] = w[9:8];
                check("R6 hold after high byte", code, held);
                do_load();
                held = stage;
                check("R2 R3 R4 parallel word", code, w);
            end
            check("R10 sdo is bit 9", {9'b0, sdo}, {9'b0, stage[9]});
        end

        // R11: low strobe held high while data changes
        @(negedge clk); stb_lo = 1'b1; din = 10'h0A5;
        @(negedge clk); din = 10'h05A;
        @(negedge clk); din = 10'h0FF;
        @(negedge clk); stb_lo = 1'b0;
        stage[7:0] = 8'hA5;
        do_load(); held = stage;
        check("R11 held low strobe", code, stage);

        // serial sweep, 10-bit words, junk on parallel inputs
        long_word = 1'b1;
        for (int k = 0; k < 1024; k++) begin
            w = 10'(k * 37 + 5);
            for (int i = 0; i < 10; i++) begin
                check("R10 sdo long", {9'b0, sdo}, {9'b0, stage[9 - i]});
                pulse(1'b1, 1'b1, 10'(~k), w[9 - i], 1'b0);
            end
            stage = w;
            check("R6 hold during shift", code, held);
            do_load(); held = stage;
            check("R7 R8 serial 10-bit", code, w);
        end

        // R11: both strobes held high for three cycles shift only once
        @(negedge clk); stb_lo = 1'b1; stb_hi = 1'b1; sdi = 1'b1;
        @(negedge clk); sdi = 1'b0;
        @(negedge clk); sdi = 1'b1;
        @(negedge clk); stb_lo = 1'b0; stb_hi = 1'b0;
        stage = {stage[8:0], 1'b1};
        do_load(); held = stage;
        check("R11 held joint strobe", code, stage);

        // serial sweep, 8-bit words
        long_word = 1'b0;
        for (int k = 0; k < 256; k++) begin
            w = {k[7:0], 2'b00};
            for (int i = 0; i < 8; i++) begin
                check("R10 sdo short", {9'b0, sdo}, {9'b0, stage[9 - i]});
                pulse(1'b1, 1'b1, 10'h3FF, w[9 - i], 1'b0);
            end
            stage = w;
            do_load(); held = stage;
            check("R9 serial 8-bit", code, w);
        end

        summary();
        $finish;
    end

endmodule